// File: doc/BRIEF.md
# Table-Driven Sampling Waveform Engine

This block is a small sequencer whose behaviour comes entirely from a byte table written by the surrounding logic. A waveform has seven programmable states (0 to 6) and a fixed idle state 7. Each programmable state is one of two kinds. A timed state lasts a programmed number of clock cycles and may capture the input bus. A decision state combines two selectable condition bits through a small logic function and jumps to one of two target states. The table holds several waveforms. A trigger pulse starts one of them, and an abort pulse ends any run at once.

Captured bytes leave on a write strobe with data toward an external FIFO. The FIFO's full flag is the only back-pressure. A capture cycle in which `fifo_full` is high produces no strobe, and that sample is dropped rather than stalling the sequence. Because the strobe is never raised while full, the FIFO cannot overflow. A waveform that must not lose data loops through a decision state that tests the FIFO flag. The control pins (trigger, abort, flag select) are plain levels sampled on the clock.

Top module: `wave_sampler`

## Requirements
- R1: After reset the engine is in state 7: `idle` is 1 and `smp_valid` is 0.
- R2: Table byte address is {wave, section[1:0], state[2:0]}. Section 0 holds the length/branch byte, section 1 the opcode, section 2 an output byte, and section 3 the logic-function byte.
- R3: A `trig` pulse while idle, with no abort, enters state 0 of waveform `wave_sel` on the next clock, and `idle` drops.
- R4: A timed state (opcode bit 0 clear) lasts N cycles, where N is its length byte and a length of 0 means 256. It then moves to the next state number, and state 6 moves to idle.
- R5: While a state with opcode bit 1 set is active, each cycle raises `smp_valid` with `smp_data` equal to `din` of that cycle.
- R6: A decision state (opcode bit 0 set) reads its branch byte as bits 5:3 for the target when true and bits 2:0 for the target when false. When bit 7 (repeat) is clear, it lasts one cycle. When bit 7 is set, it lasts two cycles, its capture action applies in both, and the branch is decided in the second.
- R7: Logic-function byte: bits 7:6 pick the function (0 A AND B, 1 A OR B, 2 A XOR B, 3 A AND NOT B). Bits 5:3 select A and bits 2:0 select B. Select codes 0-5 are `cond_in` bits, code 6 is the FIFO flag, and code 7 is constant 1.
- R8: The FIFO flag is `fifo_full` when `flag_sel` is 0 and `fifo_empty` when `flag_sel` is 1.
- R9: `abort` forces idle on the next clock, and no strobe is issued in the abort cycle.
- R10: `smp_valid` is never 1 while `fifo_full` is 1. A capture cycle under full drops its sample.
- R11: `idle` is 1 exactly in state 7, and `smp_valid` is 0 whenever `idle` is 1.
- R12: The output section and the logic-function byte of timed states have no effect on timing or captures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tbl_we | input | 1 | Table write enable |
| tbl_addr | input | ADDR_W | Table byte address |
| tbl_wdata | input | 8 | Table byte to write |
| trig | input | 1 | Start pulse, honoured when idle |
| wave_sel | input | WAVE_W | Waveform to start |
| abort | input | 1 | Stop and return to idle |
| flag_sel | input | 1 | FIFO flag choice: 0 full, 1 empty |
| fifo_full | input | 1 | FIFO full flag, blocks the write strobe |
| fifo_empty | input | 1 | FIFO empty flag |
| cond_in | input | NCOND | External condition bits |
| din | input | DATA_W | Input bus to sample |
| smp_valid | output | 1 | FIFO write strobe |
| smp_data | output | DATA_W | FIFO write data |
| idle | output | 1 | Engine is in state 7 |

## Verification
The bench builds the engine with its defaults: four waveforms, an 8-bit bus and six condition bits. This lets it place different programs in separate waveform slots and select them by `wave_sel`. With an 8-bit length byte, the wrap of length 0 to 256 cycles can be reached in one short run. Six condition bits allow the OR, XOR and AND-NOT functions to be driven from pins, while the FIFO flag code loops the capture state until full or empty is seen.

// File: rtl/wse_pkg.sv
package wse_pkg;
  localparam int ST_W = 3;
  localparam logic [ST_W-1:0] ST_IDLE = 3'd7;

  typedef enum logic [1:0] {
    SEC_LENBR = 2'd0,
    SEC_OPC   = 2'd1,
    SEC_OUT   = 2'd2,
    SEC_LFN   = 2'd3
  } sec_e;

  typedef enum logic [1:0] {
    FN_AND  = 2'd0,
    FN_OR   = 2'd1,
    FN_XOR  = 2'd2,
    FN_ANDN = 2'd3
  } lfn_e;

  function automatic logic apply_fn(lfn_e fn, logic a, logic b);
    case (fn)
      FN_AND:  return a & b;
      FN_OR:   return a | b;
      FN_XOR:  return a ^ b;
      default: return a & ~b;
    endcase
  endfunction
endpackage

// File: rtl/wse_table.sv
module wse_table
  import wse_pkg::*;
#(
  parameter int WAVES  = 4,
  parameter int WAVE_W = 2,
  localparam int ADDR_W = WAVE_W + 5,
  localparam int DEPTH  = WAVES * 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [WAVE_W-1:0] rwave,
  input  logic [ST_W-1:0]   rstate,
  output logic [7:0]        len_br,
  output logic [1:0]        opc,
  output logic [7:0]        lfn
);
  logic [7:0] mem [DEPTH];

  function automatic logic [ADDR_W-1:0] idx(logic [WAVE_W-1:0] w, sec_e s,
                                            logic [ST_W-1:0] st);
    return {w, s, st};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we && (32'(waddr) < DEPTH)) begin
      mem[waddr] <= wdata;
    end
  end

  logic [7:0] op_byte;
  always_comb begin
    len_br  = mem[idx(rwave, SEC_LENBR, rstate)];
    op_byte = mem[idx(rwave, SEC_OPC, rstate)];
    lfn     = mem[idx(rwave, SEC_LFN, rstate)];
    opc     = op_byte[1:0];
  end
endmodule

// File: rtl/wse_cond.sv
module wse_cond
  import wse_pkg::*;
#(
  parameter int NCOND = 6
) (
  input  logic [7:0]       lfn,
  input  logic [NCOND-1:0] cond_in,
  input  logic             flag_sel,
  input  logic             fifo_full,
  input  logic             fifo_empty,
  output logic             result
);
  logic [7:0] src;

  for (genvar i = 0; i < 6; i++) begin : g_src
    if (i < NCOND) begin : g_pin
      assign src[i] = cond_in[i];
    end else begin : g_zero
      assign src[i] = 1'b0;
    end
  end
  assign src[6] = flag_sel ? fifo_empty : fifo_full;
  assign src[7] = 1'b1;

  assign result = apply_fn(lfn_e'(lfn[7:6]), src[lfn[5:3]], src[lfn[2:0]]);
endmodule

// File: rtl/wse_seq.sv
module wse_seq
  import wse_pkg::*;
#(
  parameter int WAVE_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic [WAVE_W-1:0] wave_sel,
  input  logic              abort,
  input  logic              fifo_full,
  input  logic [7:0]        len_br,
  input  logic [1:0]        opc,
  input  logic              cond_res,
  output logic [ST_W-1:0]   cur,
  output logic [WAVE_W-1:0] wave,
  output logic              idle,
  output logic              smp_valid
);
  logic [7:0] cnt;
  logic       rep_ph;
  logic       is_dec, is_smp, last_cyc;

  assign idle      = (cur == ST_IDLE);
  assign is_dec    = opc[0];
  assign is_smp    = opc[1];
  assign last_cyc  = (cnt == len_br - 8'd1);
  assign smp_valid = !idle && is_smp && !fifo_full && !abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= ST_IDLE;
      wave   <= '0;
      cnt    <= '0;
      rep_ph <= 1'b0;
    end else if (abort) begin
      cur    <= ST_IDLE;
      cnt    <= '0;
      rep_ph <= 1'b0;
    end else if (idle) begin
      cnt    <= '0;
      rep_ph <= 1'b0;
      if (trig) begin
        cur  <= '0;
        wave <= wave_sel;
      end
    end else if (is_dec) begin
      cnt <= '0;
      if (len_br[7] && !rep_ph) begin
        rep_ph <= 1'b1;
      end else begin
        rep_ph <= 1'b0;
        cur    <= cond_res ? len_br[5:3] : len_br[2:0];
      end
    end else begin
      rep_ph <= 1'b0;
      if (last_cyc) begin
        cnt <= '0;
        cur <= cur + 3'd1;
      end else begin
        cnt <= cnt + 8'd1;
      end
    end
  end

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> idle); // R9
  AST_TRIG_START: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && trig && !abort) |=> (cur == 3'd0)); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> !fifo_full); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !smp_valid); // R11
  AST_REPEAT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    rep_ph |=> !rep_ph); // R6
endmodule

// File: rtl/wave_sampler.sv
module wave_sampler
  import wse_pkg::*;
#(
  parameter int WAVES  = 4,
  parameter int DATA_W = 8,
  parameter int NCOND  = 6,
  localparam int WAVE_W = (WAVES > 1) ? $clog2(WAVES) : 1,
  localparam int ADDR_W = WAVE_W + 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [7:0]        tbl_wdata,
  input  logic              trig,
  input  logic [WAVE_W-1:0] wave_sel,
  input  logic              abort,
  input  logic              flag_sel,
  input  logic              fifo_full,
  input  logic              fifo_empty,
  input  logic [NCOND-1:0]  cond_in,
  input  logic [DATA_W-1:0] din,
  output logic              smp_valid,
  output logic [DATA_W-1:0] smp_data,
  output logic              idle
);
  logic [ST_W-1:0]   cur;
  logic [WAVE_W-1:0] wave;
  logic [7:0]        len_br, lfn;
  logic [1:0]        opc;
  logic              cond_res;

  wse_table #(.WAVES(WAVES), .WAVE_W(WAVE_W)) i_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (tbl_we),
    .waddr  (tbl_addr),
    .wdata  (tbl_wdata),
    .rwave  (wave),
    .rstate (cur),
    .len_br (len_br),
    .opc    (opc),
    .lfn    (lfn)
  );

  wse_cond #(.NCOND(NCOND)) i_cond (
    .lfn        (lfn),
    .cond_in    (cond_in),
    .flag_sel   (flag_sel),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .result     (cond_res)
  );

  wse_seq #(.WAVE_W(WAVE_W)) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (trig),
    .wave_sel  (wave_sel),
    .abort     (abort),
    .fifo_full (fifo_full),
    .len_br    (len_br),
    .opc       (opc),
    .cond_res  (cond_res),
    .cur       (cur),
    .wave      (wave),
    .idle      (idle),
    .smp_valid (smp_valid)
  );

  assign smp_data = din;
endmodule

// File: tb/test_wave_sampler.sv
module test_wave_sampler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tbl_we = 1'b0;
  logic [6:0] tbl_addr = '0;
  logic [7:0] tbl_wdata = '0;
  logic       trig = 1'b0;
  logic [1:0] wave_sel = '0;
  logic       abort = 1'b0;
  logic       flag_sel = 1'b0;
  logic       fifo_full = 1'b0;
  logic       fifo_empty = 1'b0;
  logic [5:0] cond_in = '0;
  logic [7:0] din;
  logic       smp_valid;
  logic [7:0] smp_data;
  logic       idle;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  string tag = "R5";
  logic [7:0] expq[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign din = cyc[7:0];

  wave_sampler i_wave_sampler (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .trig(trig), .wave_sel(wave_sel), .abort(abort),
    .flag_sel(flag_sel), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .cond_in(cond_in), .din(din), .smp_valid(smp_valid),
    .smp_data(smp_data), .idle(idle)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Scoreboard monitor: compare each strobe with the next expected byte
  always @(negedge clk) begin
    #1;
    if (rst_n && smp_valid) begin
      if (expq.size() == 0) begin
        check(1'b0, tag, int'(smp_data), -1);
      end else begin
        automatic logic [7:0] e = expq.pop_front();
        check(smp_data == e, tag, int'(smp_data), int'(e));
      end
      check(!fifo_full, "R10", int'(fifo_full), 0);
    end
  end

  task automatic wr(int w, int sec, int st, logic [7:0] v);
    @(negedge clk);
    tbl_we = 1'b1;
    tbl_addr = 7'((w << 5) | (sec << 3) | st);
    tbl_wdata = v;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic st(int w, int s, logic [7:0] lb, logic [7:0] op, logic [7:0] lf);
    wr(w, 0, s, lb); wr(w, 1, s, op); wr(w, 2, s, 8'hFF); wr(w, 3, s, lf);
  endtask

  task automatic go(int w, output int c);
    @(negedge clk);
    wave_sel = 2'(w);
    trig = 1'b1;
    c = cyc;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic to_neg(int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic chk_idle(int t, bit exp, string req);
    to_neg(t);
    #2;
    check(idle == exp, req, int'(idle), int'(exp));
  endtask

  task automatic push(int c, int k);
    expq.push_back(8'(c + k));
  endtask

  task automatic drained(string req);
    repeat (2) @(negedge clk);
    check(expq.size() == 0, req, expq.size(), 0);
    expq.delete();
  endtask

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    int c;
    repeat (3) @(negedge clk);
    #2;
    check(idle == 1'b1, "R1", int'(idle), 1);
    check(smp_valid == 1'b0, "R1", int'(smp_valid), 0);
    rst_n = 1'b1;

    // R2 layout; R12: output bytes 0xFF and logic 0xFF in timed states
    st(0, 0, 8'd3, 8'h02, 8'hFF);
    st(0, 1, 8'd2, 8'h00, 8'hFF);
    st(0, 2, 8'd1, 8'h02, 8'hFF);
    st(0, 3, 8'h38, 8'h01, 8'h3F);
    st(1, 0, 8'd1, 8'h02, 8'h00);
    st(1, 1, 8'h38, 8'h01, 8'h36);
    st(2, 0, 8'hB9, 8'h03, 8'h40);
    st(2, 1, 8'd2, 8'h02, 8'h00);
    st(2, 2, 8'h38, 8'h01, 8'h3F);
    st(3, 0, 8'd0, 8'h02, 8'h00);
    st(3, 1, 8'h38, 8'h01, 8'h3F);

    // R3 R4 R5 R12: lengths 3,2,1 then decision to idle
    tag = "R5";
    go(0, c);
    push(c, 1); push(c, 2); push(c, 3); push(c, 6);
    #2;
    check(idle == 1'b0, "R3", int'(idle), 0);
    chk_idle(c + 7, 1'b0, "R4");
    chk_idle(c + 8, 1'b1, "R4");
    drained("R12");

    // R9: abort during capture
    tag = "R9";
    go(0, c);
    push(c, 1);
    to_neg(c + 2);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    #2;
    check(idle == 1'b1, "R9", int'(idle), 1);
    drained("R9");

    // R4: length 0 means 256 cycles
    tag = "R4";
    go(3, c);
    for (int k = 1; k <= 256; k++) push(c, k);
    chk_idle(c + 257, 1'b0, "R4");
    chk_idle(c + 258, 1'b1, "R4");
    drained("R4");

    // R8 R10: loop until full flag (flag_sel 0)
    tag = "R10";
    flag_sel = 1'b0;
    go(1, c);
    push(c, 1);
    to_neg(c + 3);
    fifo_full = 1'b1;
    chk_idle(c + 4, 1'b0, "R8");
    chk_idle(c + 5, 1'b1, "R8");
    fifo_full = 1'b0;
    drained("R10");

    // R8: empty flag selected
    tag = "R8";
    flag_sel = 1'b1;
    fifo_empty = 1'b1;
    go(1, c);
    push(c, 1);
    chk_idle(c + 3, 1'b1, "R8");
    drained("R8");
    flag_sel = 1'b0;
    fifo_empty = 1'b0;

    // R6 R7: repeat flag, OR function, true path
    tag = "R6";
    cond_in = 6'b000001;
    go(2, c);
    push(c, 1); push(c, 2);
    chk_idle(c + 2, 1'b0, "R6");
    chk_idle(c + 3, 1'b1, "R6");
    drained("R6");

    // R6 R7: false path
    cond_in = 6'b000000;
    go(2, c);
    push(c, 1); push(c, 2); push(c, 3); push(c, 4);
    chk_idle(c + 5, 1'b0, "R7");
    chk_idle(c + 6, 1'b1, "R7");
    drained("R7");

    // R7: XOR and AND-NOT in wave 3
    tag = "R7";
    st(3, 0, 8'h39, 8'h01, 8'h81);
    st(3, 1, 8'd1, 8'h02, 8'h00);
    st(3, 2, 8'h38, 8'h01, 8'h3F);
    cond_in = 6'b000001;
    go(3, c);
    chk_idle(c + 2, 1'b1, "R7");
    drained("R7");
    cond_in = 6'b000011;
    go(3, c);
    push(c, 2);
    chk_idle(c + 3, 1'b0, "R7");
    chk_idle(c + 4, 1'b1, "R7");
    drained("R7");
    wr(3, 3, 0, 8'hC1);
    cond_in = 6'b000001;
    go(3, c);
    chk_idle(c + 2, 1'b1, "R7");
    drained("R7");

    // R11: quiet while idle
    repeat (3) begin
      @(negedge clk);
      #2;
      check(idle && !smp_valid, "R11", int'(smp_valid), 0);
    end
    finish_up();
  end
endmodule